// File: doc/BRIEF.md
# Sequential Binary to Packed-Decimal Converter

This block turns an unsigned binary word into packed decimal digits, four bits per digit. It moves one binary bit per clock, most significant first, into a decimal register, and fixes every digit on each step so that no digit ever holds a value above nine. Once a conversion has started it takes a fixed number of cycles, equal to the input width, so the caller can plan for the latency.

A parameter picks one of two correction rules, and both give the same result. The pre-shift rule adds three to any digit of five or more and then doubles. The post-shift rule doubles first, lets a digit reach ten to nineteen, then adds six and passes the carry to the next higher digit. With the post-shift rule the carry ripples through every digit in one cycle. The number of digits follows from the width as ceil(WIDTH x log10 2), which is 5 digits for the default 16 bits.

A caller raises `start` for one cycle with the operand on `bin_in`. It then waits for the one-cycle `done` pulse and reads `bcd_out`, which keeps its value until the next conversion is accepted.

Top module: `bin2bcd_conv`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` and `done` are 0 and `bcd_out` is all zeros.
- R2: If `start` is high at a clock edge while `busy` is low, the converter captures `bin_in`. In the next cycle `busy` is 1 and `bcd_out` is all zeros.
- R3: Let E be the edge that accepts a start. `busy` stays high through the cycle after edge E+WIDTH-1. `done` is high only in the cycle after edge E+WIDTH.
- R4: `done` is high for exactly one cycle per conversion, and it is never high while `busy` is high.
- R5: A `start` that arrives while `busy` is high is ignored. The running conversion keeps its operand and its timing.
- R6: When `done` is high, digit i of `bcd_out` (bits 4i+3 down to 4i, with digit 0 the least significant) equals (operand / 10^i) mod 10, and no digit exceeds 9.
- R7: With MODE = ADJ_PRE (encoding 0), every digit of 5 or more gets 3 added before each shift, and the result meets R6.
- R8: With MODE = ADJ_POST (encoding 1), every digit is doubled and takes in the carry from below. Any digit that is then 10 or more gets 6 added, and its carry goes to the next higher digit. The result meets R6.
- R9: Both modes produce the same `bcd_out` for every operand value.
- R10: After `done`, `bcd_out` keeps its value, whatever happens on `bin_in`, until a start is accepted.
- R11: A `start` in the same cycle as `done` is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a conversion |
| bin_in | input | WIDTH | Unsigned operand, sampled when a start is accepted |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| bcd_out | output | 4*DIGITS | Packed decimal result, least significant digit in the low nibble |

## Verification
Two events can fall in the same cycle: the completion pulse, and the acceptance of a new start. In the sweep, the next operand is driven with `start` in the very cycle where `done` is checked. The bench then checks that the new conversion begins at once, that `done` drops after one cycle, and that the next result is still correct and on time. A start is also raised in the middle of a busy conversion with a different operand. That case is judged by `done` arriving at the original time and by the result still being the first operand's decimal value.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

   typedef enum logic {
      ADJ_PRE  = 1'b0,
      ADJ_POST = 1'b1
   } adj_mode_e;

   // Decimal digits needed for an unsigned word: ceil(w * log10(2)).
   function automatic int digits_for(input int w);
      return (w * 30103 + 99999) / 100000;
   endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell #(
   parameter bcd_conv_pkg::adj_mode_e MODE = bcd_conv_pkg::ADJ_PRE
) (
   input  logic [3:0] d_in,
   input  logic       c_in,
   output logic [3:0] d_out,
   output logic       c_out
);

   generate
      if (MODE == bcd_conv_pkg::ADJ_PRE) begin : g_pre
         // Correct first, then double: 5..9 become 8..12 so the shift carries out.
         logic [3:0] fixed;
         assign fixed = (d_in >= 4'd5) ? d_in + 4'd3 : d_in;
         assign d_out = {fixed[2:0], c_in};
         assign c_out = fixed[3];
      end else begin : g_post
         // Double first (may reach 19), then add 6 past nine; bit 4 is the carry.
         logic [4:0] dbl;
         logic [4:0] fixed;
         assign dbl   = {d_in, c_in};
         assign fixed = (dbl >= 5'd10) ? dbl + 5'd6 : dbl;
         assign d_out = fixed[3:0];
         assign c_out = fixed[4];
      end
   endgenerate

endmodule

// File: rtl/bcd_shift_array.sv
module bcd_shift_array #(
   parameter int                      DIGITS = 5,
   parameter bcd_conv_pkg::adj_mode_e MODE   = bcd_conv_pkg::ADJ_PRE,
   localparam int                     BW     = 4 * DIGITS
) (
   input  logic [BW-1:0] bcd_q,
   input  logic          bit_in,
   output logic [BW-1:0] bcd_d,
   output logic          spill
);

   logic [DIGITS:0] carry;

   assign carry[0] = bit_in;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_digit
         bcd_digit_cell #(.MODE(MODE)) u_cell (
            .d_in  (bcd_q[4*i +: 4]),
            .c_in  (carry[i]),
            .d_out (bcd_d[4*i +: 4]),
            .c_out (carry[i+1])
         );
      end
   endgenerate

   assign spill = carry[DIGITS];

endmodule

// File: rtl/bcd_step_ctrl.sv
module bcd_step_ctrl #(
   parameter int  WIDTH = 16,
   localparam int CW    = $clog2(WIDTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);

   logic [CW-1:0] cnt_q;
   logic          last;

   assign load = start && !busy;
   assign step = busy;
   assign last = (cnt_q == CW'(WIDTH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= step && last;
         if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
               busy <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/bin2bcd_conv.sv
module bin2bcd_conv #(
   parameter int                      WIDTH  = 16,
   parameter bcd_conv_pkg::adj_mode_e MODE   = bcd_conv_pkg::ADJ_PRE,
   localparam int                     DIGITS = bcd_conv_pkg::digits_for(WIDTH),
   localparam int                     BW     = 4 * DIGITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] bin_in,
   output logic             busy,
   output logic             done,
   output logic [BW-1:0]    bcd_out
);

   initial begin
      assert (WIDTH >= 2 && WIDTH <= 64)
         else $error("bin2bcd_conv: WIDTH must lie in 2..64");
      assert (DIGITS >= 1)
         else $error("bin2bcd_conv: digit count must be positive");
   end

   logic             load;
   logic             step;
   logic [WIDTH-1:0] bin_q;
   logic [BW-1:0]    bcd_q;
   logic [BW-1:0]    bcd_d;
   logic             spill;

   bcd_step_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   bcd_shift_array #(.DIGITS(DIGITS), .MODE(MODE)) u_array (
      .bcd_q  (bcd_q),
      .bit_in (bin_q[WIDTH-1]),
      .bcd_d  (bcd_d),
      .spill  (spill)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bin_q <= '0;
         bcd_q <= '0;
      end else if (load) begin
         bin_q <= bin_in;
         bcd_q <= '0;
      end else if (step) begin
         bin_q <= {bin_q[WIDTH-2:0], 1'b0};
         bcd_q <= bcd_d;
      end
   end

   assign bcd_out = bcd_q;

endmodule

// File: rtl/bcd_conv_checker.sv
module bcd_conv_checker #(
   parameter int WIDTH  = 16,
   parameter int DIGITS = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  busy,
   input logic                  done,
   input logic [4*DIGITS-1:0]   bcd_out,
   input logic                  spill
);

   logic [7:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (start && !busy) begin
         run_len <= '0;
      end else if (busy) begin
         run_len <= run_len + 1'b1;
      end
   end

   function automatic bit digits_ok(input logic [4*DIGITS-1:0] v);
      bit ok = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
         if (v[4*i +: 4] > 4'd9) ok = 1'b0;
      end
      return ok;
   endfunction

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && bcd_out == '0));

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == 8'(WIDTH)));

   assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_digits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> digits_ok(bcd_out));

   assert_no_spill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !spill);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(bcd_out));

endmodule

bind bin2bcd_conv bcd_conv_checker #(.WIDTH(WIDTH), .DIGITS(DIGITS)) u_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .bcd_out (bcd_out),
   .spill   (spill)
);

// File: tb/test_bin2bcd_conv.sv
`timescale 1ns/1ps
module test_bin2bcd_conv;

   localparam int W  = 10;
   localparam int D  = 4;
   localparam int BW = 4 * D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  bin = '0;
   logic          busy_a, done_a, busy_b, done_b;
   logic [BW-1:0] bcd_a, bcd_b;

   int total = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bin2bcd_conv #(.WIDTH(W), .MODE(bcd_conv_pkg::ADJ_PRE)) i_bin2bcd_conv (
      .clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin),
      .busy(busy_a), .done(done_a), .bcd_out(bcd_a)
   );

   bin2bcd_conv #(.WIDTH(W), .MODE(bcd_conv_pkg::ADJ_POST)) i_bin2bcd_conv_post (
      .clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin),
      .busy(busy_b), .done(done_b), .bcd_out(bcd_b)
   );

   function automatic logic [BW-1:0] ref_bcd(input int value);
      logic [BW-1:0] r = '0;
      int v = value;
      for (int i = 0; i < D; i++) begin
         r[4*i +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag, input logic b, input logic d);
      check(busy_a == b, {tag, " busy pre"},  int'(busy_a), int'(b));
      check(busy_b == b, {tag, " busy post"}, int'(busy_b), int'(b));
      check(done_a == d, {tag, " done pre"},  int'(done_a), int'(d));
      check(done_b == d, {tag, " done post"}, int'(done_b), int'(d));
   endtask

   initial begin
      logic [BW-1:0] held;
      repeat (3) @(negedge clk);
      check_state("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset", 1'b0, 1'b0);
      check(bcd_a == '0, "R1 bcd pre",  int'(bcd_a), 0);
      check(bcd_b == '0, "R1 bcd post", int'(bcd_b), 0);

      // Exhaustive sweep; each new start lands in the done cycle of the previous one (R11).
      for (int v = 0; v < (1 << W); v++) begin
         start = 1'b1;
         bin   = W'(v);
         @(negedge clk);
         start = 1'b0;
         check_state((v == 0) ? "R2 accept" : "R11 accept in done cycle, R4 pulse ends", 1'b1, 1'b0);
         check(bcd_a == '0 && bcd_b == '0, "R2 cleared", int'(bcd_a | bcd_b), 0);
         repeat (W - 1) @(negedge clk);
         check_state("R3 still busy", 1'b1, 1'b0);
         @(negedge clk);
         check_state("R3 done on time", 1'b0, 1'b1);
         check(bcd_a == ref_bcd(v), "R7 pre-shift result", int'(bcd_a), int'(ref_bcd(v)));
         check(bcd_b == ref_bcd(v), "R8 post-shift result", int'(bcd_b), int'(ref_bcd(v)));
         check(bcd_a == bcd_b, "R9 modes agree", int'(bcd_b), int'(bcd_a));
      end

      // R10: result holds while idle and bin_in moves.
      held = ref_bcd((1 << W) - 1);
      bin  = W'(555);
      repeat (5) @(negedge clk);
      check_state("R10 idle", 1'b0, 1'b0);
      check(bcd_a == held, "R10 hold pre",  int'(bcd_a), int'(held));
      check(bcd_b == held, "R10 hold post", int'(bcd_b), int'(held));

      // R5: start mid-conversion with another operand is ignored.
      start = 1'b1;
      bin   = W'(987);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1;
      bin   = W'(123);
      @(negedge clk);
      start = 1'b0;
      repeat (W - 5) @(negedge clk);
      check_state("R5 no restart, still busy", 1'b1, 1'b0);
      @(negedge clk);
      check_state("R5 done at original time", 1'b0, 1'b1);
      check(bcd_a == ref_bcd(987), "R5 operand kept pre",  int'(bcd_a), int'(ref_bcd(987)));
      check(bcd_b == ref_bcd(987), "R5 operand kept post", int'(bcd_b), int'(ref_bcd(987)));
      check(ref_bcd(987) == 16'h0987, "R6 reference digit layout", int'(ref_bcd(987)), 16'h0987);
      @(negedge clk);
      check_state("R4 single pulse", 1'b0, 1'b0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule